// File: doc/BRIEF.md
# Indirect Register Command Bridge

This block gives a host a single 64-bit command word through which it reaches the small 8-bit register set of a two-wire serial controller. The host does not address those registers directly. It writes one word that holds an opcode, a register index, a direction flag and a data byte, with the top bit set to start the access. The bridge decodes the word and carries out the internal read or write. It then places any read value in the low bits of the word and clears the top bit to show that the access has finished. The host polls the word until that bit is clear.

Four of the internal registers are plain storage: the controller's own bus address, the transfer data byte, the control byte and the clock divider byte. A fifth holds the extended bus address. All five are driven out to the serial engine. The index that selects the clock divider on writes returns the engine's live status byte on reads. Writing the reset index clears the stored registers and sends a one-cycle reset pulse to the engine.

Only one access can be in flight at a time. While an access runs, the host cannot disturb it. Opcodes other than the register-file opcode complete at once and have no effect.

Top module: `ibr_bridge`

## Requirements
- R1: While reset is high and on the first cycle after it, `cmd_o` is zero, every configuration output is zero and `eng_rst_o` is low.
- R2: When the bridge is idle (`cmd_o` bit 63 is 0), a host write with bit 63 set is captured whole into `cmd_o` at the next edge. A host write with bit 63 clear is ignored, and `cmd_o` keeps its previous value.
- R3: A write access uses opcode 6 in bits 60:57 with bit 56 = 0. It stores data bits 7:0 into the register chosen by bits 34:32: 0 is own bus address, 1 is data, 2 is control, 3 is clock divider, 4 is extended address. The new value shows on the matching configuration output. Bit 63 stays set for exactly two cycles after capture, and bits 31:0 keep the written value.
- R4: A read access uses opcode 6 with bit 56 = 1. It returns the selected register in bits 7:0 of `cmd_o`, with bits 31:8 zero, and bit 63 clears two cycles after capture. Index 3 returns `eng_stat_i` instead of the clock divider.
- R5: A write to index 7 clears all five stored registers and raises `eng_rst_o` for exactly one cycle. Writes to index 5 or 6 change nothing. Reads of index 5, 6 or 7 return zero.
- R6: A host write that arrives while bit 63 of `cmd_o` is set is ignored. The access in progress completes with the result it would have had without that write.
- R7: Any opcode other than 6 completes one cycle after capture with bits 31:0 of `cmd_o` cleared and no register or reset-pulse side effect.
- R8: Bits 62:32 of `cmd_o` keep the captured value through the access and after its completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_i | input | 1 | Host write strobe for the command word |
| host_wdata_i | input | 64 | Command word written by the host |
| cmd_o | output | 64 | Current command word as the host reads it back |
| eng_stat_i | input | 8 | Live status byte from the serial engine |
| cfg_slave_o | output | 8 | Stored own bus address |
| cfg_data_o | output | 8 | Stored transfer data byte |
| cfg_ctl_o | output | 8 | Stored control byte |
| cfg_clk_o | output | 8 | Stored clock divider byte |
| cfg_slave_ext_o | output | 8 | Stored extended bus address |
| eng_rst_o | output | 1 | One-cycle reset pulse to the serial engine |

## Verification
A new host write can land in the same cycle as an access that is still executing or is just completing. In that case, capture and completion compete for the same command register. The bench provokes this by holding a second write, with a different word, across the execute and completion cycles of a first access, and also by writing in the first cycle after the busy bit clears. It judges the outcome at the ports: the first access must finish with its own result and register side effect, the overlapping word must leave no trace, and the write issued after completion must be accepted.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  // Command word field positions (host-visible layout)
  localparam int CMD_W     = 64;
  localparam int VALID_BIT = 63;
  localparam int RD_BIT    = 56;
  localparam int OP_LSB    = 57;
  localparam int OP_W      = 4;
  localparam int IDX_LSB   = 32;
  localparam int DATA_W    = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/ibr_regfile.sv
module ibr_regfile #(
  parameter int REG_W      = 8,
  parameter int IDX_W      = 3,
  parameter int NUM_STORED = 5,
  parameter int STAT_IDX   = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic                                clr,
  input  logic [IDX_W-1:0]                    idx,
  input  logic [REG_W-1:0]                    wr_data,
  input  logic [REG_W-1:0]                    stat_i,
  output logic [REG_W-1:0]                    rd_data,
  output logic [NUM_STORED-1:0][REG_W-1:0]    regs_o
);
  localparam logic [IDX_W-1:0] STAT_SEL = IDX_W'(STAT_IDX);
  localparam logic [IDX_W-1:0] STORE_LIM = IDX_W'(NUM_STORED);

  // One flop byte per stored entry so every entry can drive the engine
  for (genvar gi = 0; gi < NUM_STORED; gi++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        regs_o[gi] <= '0;
      end else if (wr_en && idx == IDX_W'(gi)) begin
        regs_o[gi] <= wr_data;
      end
    end
  end

  // Read mux: status replaces the divider on reads, unmapped reads give zero
  always_comb begin
    rd_data = '0;
    if (idx == STAT_SEL) begin
      rd_data = stat_i;
    end else begin
      for (int k = 0; k < NUM_STORED; k++) begin
        if (idx == IDX_W'(k) && idx < STORE_LIM) rd_data = regs_o[k];
      end
    end
  end
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
  import ibr_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int IDX_W      = 3,
  parameter int OP_REG     = 6,
  parameter int NUM_STORED = 5,
  parameter int RST_IDX    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [CMD_W-1:0]  host_wdata,
  input  logic [REG_W-1:0]  rd_data,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              wr_en,
  output logic              clr,
  output logic [IDX_W-1:0]  acc_idx,
  output logic [REG_W-1:0]  wr_data,
  output logic              eng_rst_o
);
  localparam logic [OP_W-1:0]  OP_SEL    = OP_W'(OP_REG);
  localparam logic [IDX_W-1:0] RST_SEL   = IDX_W'(RST_IDX);
  localparam logic [IDX_W-1:0] STORE_LIM = IDX_W'(NUM_STORED);

  seq_state_t       state;
  logic [REG_W-1:0] rd_q;
  logic             launch;
  logic             is_reg_op;
  logic             is_read;

  assign launch    = host_wr && host_wdata[VALID_BIT] && !cmd_o[VALID_BIT];
  assign is_reg_op = cmd_o[OP_LSB +: OP_W] == OP_SEL;
  assign is_read   = cmd_o[RD_BIT];
  assign acc_idx   = cmd_o[IDX_LSB +: IDX_W];
  assign wr_data   = cmd_o[REG_W-1:0];

  // Side effects of a register-file write happen in the execute cycle only
  assign wr_en = (state == ST_EXEC) && is_reg_op && !is_read && acc_idx < STORE_LIM;
  assign clr   = (state == ST_EXEC) && is_reg_op && !is_read && acc_idx == RST_SEL;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_o     <= '0;
      rd_q      <= '0;
      eng_rst_o <= 1'b0;
    end else begin
      eng_rst_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (launch) begin
            cmd_o <= host_wdata;
            state <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (is_reg_op) begin
            rd_q      <= rd_data;
            eng_rst_o <= clr;
            state     <= ST_DONE;
          end else begin
            cmd_o[DATA_W-1:0]  <= '0;
            cmd_o[VALID_BIT]   <= 1'b0;
            state              <= ST_IDLE;
          end
        end
        ST_DONE: begin
          if (is_read) cmd_o[DATA_W-1:0] <= {{(DATA_W-REG_W){1'b0}}, rd_q};
          cmd_o[VALID_BIT] <= 1'b0;
          state            <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge #(
  parameter int REG_W      = 8,
  parameter int IDX_W      = 3,
  parameter int OP_REG     = 6,
  parameter int NUM_STORED = 5,
  parameter int STAT_IDX   = 3,
  parameter int RST_IDX    = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr_i,
  input  logic [63:0]      host_wdata_i,
  output logic [63:0]      cmd_o,
  input  logic [REG_W-1:0] eng_stat_i,
  output logic [REG_W-1:0] cfg_slave_o,
  output logic [REG_W-1:0] cfg_data_o,
  output logic [REG_W-1:0] cfg_ctl_o,
  output logic [REG_W-1:0] cfg_clk_o,
  output logic [REG_W-1:0] cfg_slave_ext_o,
  output logic             eng_rst_o
);
  logic                             wr_en;
  logic                             clr;
  logic [IDX_W-1:0]                 acc_idx;
  logic [REG_W-1:0]                 wr_data;
  logic [REG_W-1:0]                 rd_data;
  logic [NUM_STORED-1:0][REG_W-1:0] regs;

  ibr_seq #(
    .REG_W(REG_W), .IDX_W(IDX_W), .OP_REG(OP_REG),
    .NUM_STORED(NUM_STORED), .RST_IDX(RST_IDX)
  ) u_seq (
    .clk(clk), .rst(rst), .host_wr(host_wr_i), .host_wdata(host_wdata_i),
    .rd_data(rd_data), .cmd_o(cmd_o), .wr_en(wr_en), .clr(clr),
    .acc_idx(acc_idx), .wr_data(wr_data), .eng_rst_o(eng_rst_o)
  );

  ibr_regfile #(
    .REG_W(REG_W), .IDX_W(IDX_W), .NUM_STORED(NUM_STORED), .STAT_IDX(STAT_IDX)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .clr(clr), .idx(acc_idx),
    .wr_data(wr_data), .stat_i(eng_stat_i), .rd_data(rd_data), .regs_o(regs)
  );

  assign cfg_slave_o     = regs[0];
  assign cfg_data_o      = regs[1];
  assign cfg_ctl_o       = regs[2];
  assign cfg_clk_o       = regs[3];
  assign cfg_slave_ext_o = regs[4];
endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             host_wr_i,
  input logic [63:0]      host_wdata_i,
  input logic [63:0]      cmd_o,
  input logic [REG_W-1:0] cfg_slave_o,
  input logic [REG_W-1:0] cfg_data_o,
  input logic [REG_W-1:0] cfg_ctl_o,
  input logic [REG_W-1:0] cfg_clk_o,
  input logic [REG_W-1:0] cfg_slave_ext_o,
  input logic             eng_rst_o
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (cmd_o == 64'd0 && !eng_rst_o && cfg_ctl_o == '0 && cfg_slave_o == '0));

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (host_wr_i && host_wdata_i[63] && !cmd_o[63]) |=> (cmd_o == $past(host_wdata_i)));

  p_no_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (host_wr_i && !host_wdata_i[63] && !cmd_o[63]) |=> !cmd_o[63]);

  p_reg_timing_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(cmd_o[63]) && cmd_o[60:57] == 4'd6) |=> cmd_o[63] ##1 !cmd_o[63]);

  p_clear_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    eng_rst_o |-> (cfg_slave_o == '0 && cfg_data_o == '0 && cfg_ctl_o == '0 &&
                   cfg_clk_o == '0 && cfg_slave_ext_o == '0));

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    eng_rst_o |=> !eng_rst_o);

  p_cfg_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !cmd_o[63] |=> ($stable(cfg_slave_o) && $stable(cfg_data_o) && $stable(cfg_ctl_o) &&
                    $stable(cfg_clk_o) && $stable(cfg_slave_ext_o)));

  p_fast_done_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(cmd_o[63]) && cmd_o[60:57] != 4'd6) |=> (!cmd_o[63] && cmd_o[31:0] == 32'd0));

  p_upper_hold_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_o[63] |=> $stable(cmd_o[62:32]));
endmodule

bind ibr_bridge ibr_bridge_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i),
  .cmd_o(cmd_o), .cfg_slave_o(cfg_slave_o), .cfg_data_o(cfg_data_o),
  .cfg_ctl_o(cfg_ctl_o), .cfg_clk_o(cfg_clk_o), .cfg_slave_ext_o(cfg_slave_ext_o),
  .eng_rst_o(eng_rst_o)
);

// File: tb/ibr_bridge_bench.sv
`timescale 1ns/1ps
module ibr_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_i = 1'b0;
  logic [63:0] host_wdata_i = '0;
  logic [63:0] cmd_o;
  logic [7:0]  eng_stat_i = '0;
  logic [7:0]  cfg_slave_o, cfg_data_o, cfg_ctl_o, cfg_clk_o, cfg_slave_ext_o;
  logic        eng_rst_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [5];

  always #5 clk = ~clk;

  ibr_bridge u_ibr_bridge (
    .clk(clk), .rst(rst), .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i),
    .cmd_o(cmd_o), .eng_stat_i(eng_stat_i), .cfg_slave_o(cfg_slave_o),
    .cfg_data_o(cfg_data_o), .cfg_ctl_o(cfg_ctl_o), .cfg_clk_o(cfg_clk_o),
    .cfg_slave_ext_o(cfg_slave_ext_o), .eng_rst_o(eng_rst_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [3:0] op, input bit rd, input logic [2:0] idx,
                                     input logic [31:0] dat, input logic [63:0] noise);
    logic [63:0] w;
    w = noise;
    w[63] = 1'b1; w[60:57] = op; w[56] = rd; w[34:32] = idx; w[31:0] = dat;
    return w;
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] idx, input logic [7:0] st);
    if (idx == 3'd3) return st;
    if (idx < 3'd5)  return model[idx];
    return 8'd0;
  endfunction

  task automatic chk_cfg(input string req);
    logic [39:0] act, exp;
    act = {cfg_slave_ext_o, cfg_clk_o, cfg_ctl_o, cfg_data_o, cfg_slave_o};
    exp = {model[4], model[3], model[2], model[1], model[0]};
    chk(act == exp, req, {24'd0, act}, {24'd0, exp});
  endtask

  // Launch a word (caller is just after a negedge); optionally hold a second
  // write over the busy cycles to provoke overlap.
  task automatic run_cmd(input logic [63:0] w, input bit overlap, input logic [63:0] w2,
                         output int cyc, output int pulses, output logic [63:0] res,
                         output bit seen_valid);
    host_wr_i = 1'b1; host_wdata_i = w;
    @(negedge clk);
    seen_valid = cmd_o[63];
    pulses = eng_rst_o ? 1 : 0;
    if (overlap) begin host_wr_i = 1'b1; host_wdata_i = w2; end
    else host_wr_i = 1'b0;
    cyc = 0;
    while (cmd_o[63] && cyc < 20) begin
      @(negedge clk);
      cyc++;
      if (eng_rst_o) pulses++;
    end
    host_wr_i = 1'b0;
    res = cmd_o;
  endtask

  task automatic do_one(input logic [63:0] w, input logic [7:0] st, input bit overlap,
                        input logic [63:0] w2);
    int cyc, pulses;
    logic [63:0] res, expw;
    bit sv;
    int exp_cyc, exp_pulses;
    logic [3:0] op; bit rd; logic [2:0] idx;
    op = w[60:57]; rd = w[56]; idx = w[34:32];
    eng_stat_i = st;
    expw = w; expw[63] = 1'b0;
    exp_pulses = 0;
    if (op != 4'd6) begin
      exp_cyc = 1; expw[31:0] = '0;
    end else begin
      exp_cyc = 2;
      if (rd) expw[31:0] = {24'd0, exp_read(idx, st)};
      else if (idx < 3'd5) model[idx] = w[7:0];
      else if (idx == 3'd7) begin
        for (int k = 0; k < 5; k++) model[k] = 8'd0;
        exp_pulses = 1;
      end
    end
    run_cmd(w, overlap, w2, cyc, pulses, res, sv);
    chk(sv, "R2 valid set after capture", {63'd0, sv}, 64'd1);
    if (cyc >= 20) chk(1'b0, "R2 watchdog on busy", 64'(cyc), 64'(exp_cyc));
    if (op != 4'd6) chk(cyc == exp_cyc, "R7 fast completion", 64'(cyc), 64'(exp_cyc));
    else chk(cyc == exp_cyc, rd ? "R4 read completion" : "R3 write completion", 64'(cyc), 64'(exp_cyc));
    chk(res[62:32] == expw[62:32], "R8 upper fields", res, expw);
    if (op != 4'd6) chk(res == expw, "R7 zero data", res, expw);
    else if (rd) chk(res == expw, "R4 read data", res, expw);
    else chk(res == expw, "R3 write word", res, expw);
    chk(pulses == exp_pulses, "R5 reset pulse", 64'(pulses), 64'(exp_pulses));
    if (overlap) chk_cfg("R6 overlap side effect");
    else chk_cfg("R3 cfg outputs");
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "R1 watchdog expired", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] prev, w;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 5; k++) model[k] = 8'd0;
    repeat (3) @(negedge clk);
    chk(cmd_o == 64'd0 && !eng_rst_o, "R1 reset word", cmd_o, 64'd0);
    chk_cfg("R1 reset cfg");
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_o == 64'd0, "R1 after release", cmd_o, 64'd0);

    // Directed: write each stored register, then read it back
    for (int i = 0; i < 5; i++)
      do_one(mk(4'd6, 1'b0, 3'(i), 32'hA5A5_0010 + 32'(i), 64'h1234_5678_9ABC_DEF0), 8'h3C, 1'b0, '0);
    for (int i = 0; i < 8; i++)
      do_one(mk(4'd6, 1'b1, 3'(i), 32'hFFFF_FFFF, 64'h0), 8'h9E, 1'b0, '0);
    // Writes to unmapped indices 5 and 6 change nothing
    do_one(mk(4'd6, 1'b0, 3'd5, 32'h77, '0), 8'h00, 1'b0, '0);
    do_one(mk(4'd6, 1'b0, 3'd6, 32'h88, '0), 8'h00, 1'b0, '0);
    // Unused opcode, both directions
    do_one(mk(4'd2, 1'b0, 3'd1, 32'hDEAD_BEEF, 64'h0F0F), 8'h11, 1'b0, '0);
    do_one(mk(4'd15, 1'b1, 3'd0, 32'hCAFE_F00D, '0), 8'h11, 1'b0, '0);
    // Clear via index 7
    do_one(mk(4'd6, 1'b0, 3'd7, 32'h0, '0), 8'h00, 1'b0, '0);

    // Write with valid clear is ignored (R2)
    prev = cmd_o;
    w = mk(4'd6, 1'b0, 3'd2, 32'h5A, '0); w[63] = 1'b0;
    host_wr_i = 1'b1; host_wdata_i = w;
    @(negedge clk); host_wr_i = 1'b0;
    @(negedge clk);
    chk(cmd_o == prev, "R2 no launch without valid", cmd_o, prev);
    chk_cfg("R2 no side effect");

    // Overlap: second word held over execute and completion cycles (R6)
    do_one(mk(4'd6, 1'b0, 3'd2, 32'h0000_00C3, '0), 8'h00, 1'b1,
           mk(4'd6, 1'b0, 3'd2, 32'h0000_003C, 64'hFFFF_0000_0000_0000));
    do_one(mk(4'd6, 1'b1, 3'd2, 32'h0, '0), 8'h00, 1'b1, mk(4'd6, 1'b0, 3'd7, 32'h0, '0));
    // Write right after completion is accepted
    do_one(mk(4'd6, 1'b0, 3'd0, 32'h0000_0042, '0), 8'h00, 1'b0, '0);

    // Constrained random mix
    for (int n = 0; n < 300; n++) begin
      logic [3:0] op; logic [63:0] nz;
      op = ($urandom % 4 != 0) ? 4'd6 : 4'($urandom);
      nz = {$urandom, $urandom};
      do_one(mk(op, 1'($urandom), 3'($urandom), $urandom, nz), 8'($urandom),
             ($urandom % 8 == 0), {$urandom, $urandom} | 64'h8000_0000_0000_0000);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule